// File: doc/BRIEF.md
# Eight-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for eight-bit operands. It takes two operands, a carry input and a three-bit function code. It returns an eight-bit result together with a carry flag and a signed overflow flag. No clock or reset reaches the block: every output follows its inputs with only gate delay.

Two sections run in parallel. A bitwise section repeats one bit slice across the word and offers four functions. An arithmetic section offers four operations, built from a ripple-carry adder, an operand inverter, an all-ones constant and a separate chain of half adders for the increment. The top bit of the function code makes the final choice between the two sections. The lower two bits pick the operation inside each section and also pick the carry and overflow flags.

Top module: `alu8_core`

## Requirements
- R1: With fn_i = 3'b000 the result is the low eight bits of a_i + b_i + carry_i, and carry_o is the ninth bit of that sum.
- R2: With fn_i = 3'b001 the result is the low eight bits of a_i + (~b_i) + carry_i, and carry_o is the ninth bit of that sum.
- R3: With fn_i = 3'b010 the result is a_i + 8'hFF with no carry added, so carry_i has no effect; a_i = 0 wraps to 8'hFF with carry_o = 0, and every other a_i gives a_i - 1 with carry_o = 1.
- R4: With fn_i = 3'b011 the result is a_i + carry_i; a_i = 8'hFF with carry_i = 1 gives 8'h00 with carry_o = 1.
- R5: For fn_i = 3'b010 and fn_i = 3'b011, b_i has no effect on any output.
- R6: With fn_i[2] = 1 the result is a_i AND b_i for fn_i[1:0] = 00, a_i OR b_i for 01, a_i XOR b_i for 10, and NOT a_i for 11.
- R7: With fn_i[2] = 1 both carry_o and ovf_o are 0, and carry_i has no effect on the result.
- R8: In arithmetic mode (fn_i[2] = 0) ovf_o is 1 exactly when the two addends of the chosen addition share bit 7 and bit 7 of the result differs from it. The addends are b_i, ~b_i, 8'hFF and 8'h00 for codes 00, 01, 10 and 11.
- R9: fn_i[2] = 0 selects the arithmetic result and fn_i[2] = 1 selects the bitwise result, with no other decoding of the function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand, used by the add, add-inverted and bitwise functions |
| carry_i | input | 1 | Carry input for the add, add-inverted and increment operations |
| fn_i | input | 3 | Function code: bit 2 picks the section, bits 1:0 pick the operation |
| y_o | output | 8 | Result |
| carry_o | output | 1 | Carry out of the selected addition, 0 in bitwise mode |
| ovf_o | output | 1 | Signed two's-complement overflow of the selected addition, 0 in bitwise mode |

## Verification
The assertions are immediate checks that assume every input carries a defined 0 or 1. A value with unknown bits would make the equality checks on the adder chains meaningless. The bench therefore drives every port from its first cycle, holds all inputs at zero while its reset is low, and changes them only on a rising clock edge, half a period before the next sample. Only full-range eight-bit values are applied, so the arithmetic identities checked inside the adder modules stay defined at all times.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned FN_W = 3;

  typedef enum logic [1:0] {
    AR_ADD  = 2'b00,
    AR_ADDN = 2'b01,
    AR_DEC  = 2'b10,
    AR_INC  = 2'b11
  } arith_op_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_NOTA = 2'b11
  } logic_op_e;

endpackage

// File: rtl/alu8_half_add.sv
module alu8_half_add (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);

  always_comb begin
    s_o = x_i ^ y_i;
    c_o = x_i & y_i;
  end

endmodule

// File: rtl/alu8_full_add.sv
module alu8_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic s_lo, c_lo, c_hi;

  alu8_half_add u_ha_lo (.x_i(x_i),  .y_i(y_i), .s_o(s_lo), .c_o(c_lo));
  alu8_half_add u_ha_hi (.x_i(s_lo), .y_i(c_i), .s_o(s_o),  .c_o(c_hi));

  assign c_o = c_lo | c_hi;

endmodule

// File: rtl/alu8_ripple_add.sv
module alu8_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o,
  output logic         v_o
);

  logic [W:0] cy;

  assign cy[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    alu8_full_add u_fa (
      .x_i(a_i[i]),
      .y_i(b_i[i]),
      .c_i(cy[i]),
      .s_o(s_o[i]),
      .c_o(cy[i+1])
    );
  end

  assign c_o = cy[W];
  assign v_o = ~(a_i[W-1] ^ b_i[W-1]) & (s_o[W-1] ^ a_i[W-1]);

  // R1 / R2: the bit chain must equal the arithmetic sum
  always_comb begin
    a_r1_chain_sum: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i}))
      else $error("ripple chain sum mismatch");
  end

endmodule

// File: rtl/alu8_inc_chain.sv
module alu8_inc_chain #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o,
  output logic         v_o
);

  logic [W:0] cy;

  assign cy[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    alu8_half_add u_ha (
      .x_i(a_i[i]),
      .y_i(cy[i]),
      .s_o(s_o[i]),
      .c_o(cy[i+1])
    );
  end

  assign c_o = cy[W];
  // second addend is zero, so only a positive operand can overflow
  assign v_o = ~a_i[W-1] & s_o[W-1];

  always_comb begin
    a_r4_inc_value: assert ({c_o, s_o} == ({1'b0, a_i} + {{W{1'b0}}, c_i}))
      else $error("increment chain mismatch");
  end

endmodule

// File: rtl/alu8_mux4.sv
module alu8_mux4 #(
  parameter int unsigned W = 8
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] d0_i,
  input  logic [W-1:0] d1_i,
  input  logic [W-1:0] d2_i,
  input  logic [W-1:0] d3_i,
  output logic [W-1:0] q_o
);

  always_comb begin
    unique case (sel_i)
      2'b00:   q_o = d0_i;
      2'b01:   q_o = d1_i;
      2'b10:   q_o = d2_i;
      default: q_o = d3_i;
    endcase
  end

endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] y_o
);

  logic [W-1:0] f_and, f_or, f_xor, f_nota;

  // one bit slice per position
  for (genvar i = 0; i < W; i++) begin : g_slice
    always_comb begin
      f_and[i]  = a_i[i] & b_i[i];
      f_or[i]   = a_i[i] | b_i[i];
      f_xor[i]  = a_i[i] ^ b_i[i];
      f_nota[i] = ~a_i[i];
    end
  end

  alu8_mux4 #(.W(W)) u_pick (
    .sel_i(op_i),
    .d0_i(f_and),
    .d1_i(f_or),
    .d2_i(f_xor),
    .d3_i(f_nota),
    .q_o(y_o)
  );

  always_comb begin
    if (op_i == LG_NOTA)
      a_r6_not_a: assert ((y_o & a_i) == '0 && (y_o | a_i) == '1)
        else $error("complement of a wrong");
    if (op_i == LG_XOR)
      a_r6_xor: assert ((y_o ^ b_i) == a_i)
        else $error("xor wrong");
  end

endmodule

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] y_o,
  output logic         c_o,
  output logic         v_o
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] b_inv;
  logic [W-1:0] s_add, s_addn, s_dec, s_inc;
  logic         c_add, c_addn, c_dec, c_inc;
  logic         v_add, v_addn, v_dec, v_inc;

  assign b_inv = ~b_i;

  alu8_ripple_add #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .s_o(s_add), .c_o(c_add), .v_o(v_add)
  );

  alu8_ripple_add #(.W(W)) u_addn (
    .a_i(a_i), .b_i(b_inv), .c_i(c_i),
    .s_o(s_addn), .c_o(c_addn), .v_o(v_addn)
  );

  // decrement: add the all-ones constant, carry input tied low
  alu8_ripple_add #(.W(W)) u_dec (
    .a_i(a_i), .b_i(ALL_ONES), .c_i(1'b0),
    .s_o(s_dec), .c_o(c_dec), .v_o(v_dec)
  );

  alu8_inc_chain #(.W(W)) u_inc (
    .a_i(a_i), .c_i(c_i),
    .s_o(s_inc), .c_o(c_inc), .v_o(v_inc)
  );

  alu8_mux4 #(.W(W)) u_pick_y (
    .sel_i(op_i),
    .d0_i(s_add), .d1_i(s_addn), .d2_i(s_dec), .d3_i(s_inc),
    .q_o(y_o)
  );

  alu8_mux4 #(.W(1)) u_pick_c (
    .sel_i(op_i),
    .d0_i(c_add), .d1_i(c_addn), .d2_i(c_dec), .d3_i(c_inc),
    .q_o(c_o)
  );

  alu8_mux4 #(.W(1)) u_pick_v (
    .sel_i(op_i),
    .d0_i(v_add), .d1_i(v_addn), .d2_i(v_dec), .d3_i(v_inc),
    .q_o(v_o)
  );

  always_comb begin
    if (op_i == AR_DEC) begin
      a_r3_dec_carry: assert (c_o == (a_i != '0))
        else $error("decrement carry wrong");
      a_r8_dec_ovf: assert (v_o == (a_i[W-1] & ~y_o[W-1]))
        else $error("decrement overflow wrong");
    end
    if (op_i == AR_INC && a_i == ALL_ONES && c_i)
      a_r4_inc_wrap: assert (y_o == '0 && c_o)
        else $error("increment wrap wrong");
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            carry_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [W-1:0]    y_o,
  output logic            carry_o,
  output logic            ovf_o
);

  logic [W-1:0] y_arith, y_logic;
  logic         c_arith, v_arith;
  logic         pick_logic;

  assign pick_logic = fn_i[FN_W-1];

  alu8_arith_unit #(.W(W)) u_arith (
    .a_i(a_i), .b_i(b_i), .c_i(carry_i), .op_i(fn_i[1:0]),
    .y_o(y_arith), .c_o(c_arith), .v_o(v_arith)
  );

  alu8_logic_unit #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(fn_i[1:0]),
    .y_o(y_logic)
  );

  always_comb begin
    y_o     = pick_logic ? y_logic : y_arith;
    carry_o = pick_logic ? 1'b0    : c_arith;
    ovf_o   = pick_logic ? 1'b0    : v_arith;
  end

  always_comb begin
    if (pick_logic)
      a_r7_logic_flags: assert (!carry_o && !ovf_o)
        else $error("flags set in bitwise mode");
    else
      a_r9_arith_path: assert (y_o == y_arith && carry_o == c_arith)
        else $error("arithmetic result not routed");
  end

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

  logic       clk;
  logic       rst_n;
  logic [7:0] a, b;
  logic       cin;
  logic [2:0] fn;
  logic [7:0] y;
  logic       cout, ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  alu8_core u0 (
    .a_i(a), .b_i(b), .carry_i(cin), .fn_i(fn),
    .y_o(y), .carry_o(cout), .ovf_o(ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 4 ns period

  // {fn, a, b, cin, y, cout, ovf}
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    {3'b000, 8'h3C, 8'h42, 1'b0, 8'h7E, 1'b0, 1'b0},  // R1
    {3'b000, 8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b1},  // R1 R8
    {3'b000, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0},  // R1
    {3'b000, 8'h80, 8'h80, 1'b1, 8'h01, 1'b1, 1'b1},  // R1 R8
    {3'b001, 8'h50, 8'h20, 1'b1, 8'h30, 1'b1, 1'b0},  // R2
    {3'b001, 8'h20, 8'h50, 1'b1, 8'hD0, 1'b0, 1'b0},  // R2
    {3'b001, 8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 1'b1},  // R2 R8
    {3'b010, 8'h00, 8'h55, 1'b1, 8'hFF, 1'b0, 1'b0},  // R3
    {3'b010, 8'h80, 8'h00, 1'b0, 8'h7F, 1'b1, 1'b1},  // R3 R8
    {3'b010, 8'h01, 8'hC3, 1'b1, 8'h00, 1'b1, 1'b0},  // R3
    {3'b011, 8'hFF, 8'hAA, 1'b1, 8'h00, 1'b1, 1'b0},  // R4
    {3'b011, 8'h7F, 8'h00, 1'b1, 8'h80, 1'b0, 1'b1},  // R4 R8
    {3'b011, 8'h34, 8'hFF, 1'b0, 8'h34, 1'b0, 1'b0},  // R4
    {3'b100, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b0, 1'b0},  // R6 R7
    {3'b101, 8'hF0, 8'h0C, 1'b0, 8'hFC, 1'b0, 1'b0},  // R6
    {3'b110, 8'hFF, 8'h0F, 1'b1, 8'hF0, 1'b0, 1'b0},  // R6 R7
    {3'b111, 8'h5A, 8'hFF, 1'b0, 8'hA5, 1'b0, 1'b0}   // R6
  };

  // reference written from the requirements: {y, cout, ovf}
  function automatic logic [9:0] model(input logic [2:0] f, input logic [7:0] x,
                                       input logic [7:0] z, input logic c);
    logic [7:0] addend;
    logic       cc;
    logic [8:0] t;
    logic [7:0] r;
    if (!f[2]) begin
      case (f[1:0])
        2'b00:   begin addend = z;     cc = c;    end
        2'b01:   begin addend = ~z;    cc = c;    end
        2'b10:   begin addend = 8'hFF; cc = 1'b0; end
        default: begin addend = 8'h00; cc = c;    end
      endcase
      t = {1'b0, x} + {1'b0, addend} + {8'h00, cc};
      return {t[7:0], t[8], (x[7] == addend[7]) && (t[7] != x[7])};
    end
    case (f[1:0])
      2'b00:   r = x & z;
      2'b01:   r = x | z;
      2'b10:   r = x ^ z;
      default: r = ~x;
    endcase
    return {r, 2'b00};
  endfunction

  task automatic apply(input logic [2:0] f, input logic [7:0] x, input logic [7:0] z,
                       input logic c, input logic [9:0] exp, input string req);
    @(posedge clk);
    fn = f; a = x; b = z; cin = c;
    @(negedge clk);
    checks++;
    if ({y, cout, ovf} !== exp) begin
      errors++;
      $display("FAIL %s fn=%b a=%h b=%h cin=%b: got y=%h c=%b v=%b, expected y=%h c=%b v=%b",
               req, f, x, z, c, y, cout, ovf, exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    fn = '0; a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // reset state: all-zero inputs add to zero (R1)
    if ({y, cout, ovf} !== 10'd0) begin
      errors++;
      $display("FAIL R1 reset: got %h, expected 000", {y, cout, ovf});
    end
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++)
      apply(VEC[i][29:27], VEC[i][26:19], VEC[i][18:11], VEC[i][10], VEC[i][9:0], "R-table");

    // R3 carry input ignored by decrement, R5 b ignored by decrement and increment
    for (int k = 0; k < 8; k++) begin
      logic [7:0] av = 8'(k * 37);
      logic [7:0] bv = 8'(k * 91 + 5);
      apply(3'b010, av, bv, 1'b1, model(3'b010, av, 8'h00, 1'b0), "R3 R5 dec");
      apply(3'b011, av, bv, 1'b1, model(3'b011, av, 8'h00, 1'b1), "R5 inc");
    end

    // R7: carry input has no effect in bitwise mode
    for (int f = 4; f < 8; f++)
      apply(3'(f), 8'hC6, 8'h5B, 1'b1, model(3'(f), 8'hC6, 8'h5B, 1'b0), "R7 R9");

    // sweep of all codes (R1 R2 R4 R6 R8 R9)
    for (int f = 0; f < 8; f++)
      for (int ai = 0; ai < 256; ai += 17)
        for (int bi = 0; bi < 256; bi += 51)
          for (int c = 0; c < 2; c++)
            apply(3'(f), 8'(ai), 8'(bi), 1'(c),
                  model(3'(f), 8'(ai), 8'(bi), 1'(c)), "R8 R9 sweep");

    // corner: decrement of zero and increment wrap once more (R3 R4)
    apply(3'b010, 8'h00, 8'hFF, 1'b0, {8'hFF, 1'b0, 1'b0}, "R3 zero");
    apply(3'b011, 8'hFF, 8'h00, 1'b1, {8'h00, 1'b1, 1'b0}, "R4 wrap");

    finish_run();
  end

endmodule